// File: doc/BRIEF.md
# Extension Context Status Tracker

This block keeps the two 2-bit status fields that a machine status register uses to describe two optional groups of architectural state. One field covers the floating-point group, which is the floating-point control/status CSR and the floating-point data registers. The other field covers a custom-extension group. Software reads and writes the fields through a CSR write port. The hardware also changes them in two ways. It raises an illegal-instruction request when an instruction touches a group whose field is Off. It promotes a field to Dirty when a legal instruction retires that modifies the guarded state. Writing a field never touches the guarded state itself. This block stores only the status and has no path to that state.

Each field is a small state machine. Its states are OFF (code 0), INIT (code 1), CLEAN (code 2) and DIRTY (code 3). In each cycle the machine takes exactly one of four named moves:
- HOLD keeps the current state.
- LOAD takes the value written by software.
- MARK jumps to DIRTY because of a legal retired write.
- LOAD_MARK applies the software value and then the promotion, which leaves DIRTY.

The parameters `HAS_FP` and `HAS_CX` select whether each group exists. An absent group's field is fixed at OFF.

Top module: `ext_ctx_status`

## Requirements
- R1: After reset, both status fields read OFF (code 0) and `illegal_req` is low while no instruction is valid.
- R2: In the same cycle, `illegal_req` is high when a valid instruction asserts `ins_fp_access` or `ins_fp_write` while the floating-point field is OFF.
- R3: In the same cycle, `illegal_req` is high when a valid instruction asserts `ins_cx_op` while the custom field is OFF.
- R4: On the cycle after a retired, legal, valid instruction with `ins_fp_write` high, the floating-point field reads DIRTY (code 3) if it was INIT (1) or CLEAN (2). An access without `ins_fp_write` leaves the field unchanged.
- R5: On the cycle after a retired, legal, valid instruction with `ins_cx_op` high, the custom field reads DIRTY (code 3) if it was not OFF.
- R6: An instruction that raises `illegal_req` promotes neither field, even when it retires.
- R7: When `csr_wr_en` is high, each present field takes its written 2-bit code (0 to 3) on the next cycle.
- R8: When a CSR write and a legal retired promotion land in the same cycle, the field reads DIRTY next cycle if the written code is not OFF. If the written code is OFF, the field reads OFF.
- R9: A group whose presence parameter is 0 always reads code 0, ignores CSR writes and never promotes. Any instruction that touches that group raises `illegal_req`.
- R10: Without `retire` or `csr_wr_en`, neither field changes. Without `ins_valid`, `illegal_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction flags below are meaningful |
| ins_fp_access | input | 1 | Instruction reads or writes floating-point state |
| ins_fp_write | input | 1 | Instruction modifies floating-point state |
| ins_cx_op | input | 1 | Instruction belongs to the custom extension |
| retire | input | 1 | Instruction completes this cycle |
| csr_wr_en | input | 1 | Software write to the status fields |
| csr_wr_fs | input | 2 | Value written to the floating-point field |
| csr_wr_xs | input | 2 | Value written to the custom field |
| illegal_req | output | 1 | Illegal-instruction request, combinational |
| fs_state | output | 2 | Current floating-point status code |
| xs_state | output | 2 | Current custom status code |

## Verification
`illegal_req` is combinational. It is due in the same cycle the instruction flags are driven. Field changes from writes or promotions appear one clock edge later. For each driven cycle, the scoreboard stores an expected trap value and the expected field values after the edge. The monitor compares the trap value one nanosecond after the falling edge that applied the stimulus. It compares the field values one nanosecond after the following rising edge. A second instance with both groups absent gets the same stimulus and is checked against constant OFF fields.

// File: rtl/ext_ctx_pkg.sv
package ext_ctx_pkg;

    localparam int CTX_W = 2;

    typedef enum logic [CTX_W-1:0] {
        CTX_OFF   = 2'd0,
        CTX_INIT  = 2'd1,
        CTX_CLEAN = 2'd2,
        CTX_DIRTY = 2'd3
    } ctx_state_e;

    typedef enum logic [1:0] {
        MV_HOLD      = 2'b00,
        MV_MARK      = 2'b01,
        MV_LOAD      = 2'b10,
        MV_LOAD_MARK = 2'b11
    } ctx_move_e;

endpackage

// File: rtl/ext_ctx_gate.sv
module ext_ctx_gate
    import ext_ctx_pkg::*;
(
    input  logic             ins_valid,
    input  logic             ins_fp_access,
    input  logic             ins_fp_write,
    input  logic             ins_cx_op,
    input  logic             retire,
    input  logic [CTX_W-1:0] fs_cur,
    input  logic [CTX_W-1:0] xs_cur,
    output logic             illegal,
    output logic             fp_promote,
    output logic             cx_promote
);

    logic fp_trap;
    logic cx_trap;
    logic commit;

    always_comb begin
        fp_trap    = ins_valid && (ins_fp_access || ins_fp_write) && (fs_cur == CTX_OFF);
        cx_trap    = ins_valid && ins_cx_op && (xs_cur == CTX_OFF);
        illegal    = fp_trap || cx_trap;
        commit     = ins_valid && retire && !illegal;
        fp_promote = commit && ins_fp_write;
        cx_promote = commit && ins_cx_op;
    end

endmodule

// File: rtl/ext_ctx_field.sv
module ext_ctx_field
    import ext_ctx_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_val,
    input  logic             promote,
    output logic [CTX_W-1:0] state_o
);

    generate
        if (PRESENT) begin : g_live
            ctx_state_e state_q;
            ctx_state_e state_d;
            ctx_state_e base;
            ctx_move_e  move;
            logic       mark;

            always_comb begin
                base = wr_en ? ctx_state_e'(wr_val) : state_q;
                mark = promote && (base != CTX_OFF);
                move = ctx_move_e'({wr_en, mark});
                state_d = state_q;
                unique case (move)
                    MV_HOLD:      state_d = state_q;
                    MV_LOAD:      state_d = ctx_state_e'(wr_val);
                    MV_MARK:      state_d = CTX_DIRTY;
                    MV_LOAD_MARK: state_d = CTX_DIRTY;
                    default:      state_d = state_q;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= CTX_OFF;
                else        state_q <= state_d;
            end

            always_comb begin
                state_o = state_q;
            end
        end else begin : g_absent
            always_comb begin
                state_o = CTX_OFF;
            end
        end
    endgenerate

endmodule

// File: rtl/ext_ctx_status.sv
module ext_ctx_status
    import ext_ctx_pkg::*;
#(
    parameter bit HAS_FP = 1'b1,
    parameter bit HAS_CX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ins_fp_access,
    input  logic             ins_fp_write,
    input  logic             ins_cx_op,
    input  logic             retire,
    input  logic             csr_wr_en,
    input  logic [CTX_W-1:0] csr_wr_fs,
    input  logic [CTX_W-1:0] csr_wr_xs,
    output logic             illegal_req,
    output logic [CTX_W-1:0] fs_state,
    output logic [CTX_W-1:0] xs_state
);

    logic fp_promote;
    logic cx_promote;

    ext_ctx_gate u_gate (
        .ins_valid     (ins_valid),
        .ins_fp_access (ins_fp_access),
        .ins_fp_write  (ins_fp_write),
        .ins_cx_op     (ins_cx_op),
        .retire        (retire),
        .fs_cur        (fs_state),
        .xs_cur        (xs_state),
        .illegal       (illegal_req),
        .fp_promote    (fp_promote),
        .cx_promote    (cx_promote)
    );

    ext_ctx_field #(.PRESENT(HAS_FP)) u_fs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .wr_val  (csr_wr_fs),
        .promote (fp_promote),
        .state_o (fs_state)
    );

    ext_ctx_field #(.PRESENT(HAS_CX)) u_xs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .wr_val  (csr_wr_xs),
        .promote (cx_promote),
        .state_o (xs_state)
    );

endmodule

// File: rtl/ext_ctx_status_chk.sv
module ext_ctx_status_chk #(
    parameter bit HAS_FP = 1'b1,
    parameter bit HAS_CX = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ins_valid,
    input logic       ins_fp_access,
    input logic       ins_fp_write,
    input logic       ins_cx_op,
    input logic       retire,
    input logic       csr_wr_en,
    input logic [1:0] csr_wr_fs,
    input logic [1:0] csr_wr_xs,
    input logic       illegal_req,
    input logic [1:0] fs_state,
    input logic [1:0] xs_state
);

    logic fp_legal_wr;
    logic cx_legal_op;
    assign fp_legal_wr = ins_valid && retire && ins_fp_write && !illegal_req;
    assign cx_legal_op = ins_valid && retire && ins_cx_op && !illegal_req;

    assert_fp_off_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_fp_access || ins_fp_write) && fs_state == 2'd0) |-> illegal_req);

    assert_cx_off_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_cx_op && xs_state == 2'd0) |-> illegal_req);

    assert_fp_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_FP && fp_legal_wr && !csr_wr_en) |=> (fs_state == 2'd3));

    assert_cx_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CX && cx_legal_op && !csr_wr_en) |=> (xs_state == 2'd3));

    assert_trap_no_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_req && !csr_wr_en) |=> ($stable(fs_state) && $stable(xs_state)));

    assert_csr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_FP && csr_wr_en && !fp_legal_wr) |=> (fs_state == $past(csr_wr_fs)));

    assert_write_then_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_FP && csr_wr_en && fp_legal_wr && csr_wr_fs != 2'd0) |=> (fs_state == 2'd3));

    assert_write_off_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CX && csr_wr_en && csr_wr_xs == 2'd0) |=> (xs_state == 2'd0));

    assert_absent_fp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_FP |-> (fs_state == 2'd0));

    assert_absent_cx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_CX |-> (xs_state == 2'd0));

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !csr_wr_en) |=> ($stable(fs_state) && $stable(xs_state)));

    assert_no_valid_no_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !illegal_req);

endmodule

bind ext_ctx_status ext_ctx_status_chk #(.HAS_FP(HAS_FP), .HAS_CX(HAS_CX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_valid     (ins_valid),
    .ins_fp_access (ins_fp_access),
    .ins_fp_write  (ins_fp_write),
    .ins_cx_op     (ins_cx_op),
    .retire        (retire),
    .csr_wr_en     (csr_wr_en),
    .csr_wr_fs     (csr_wr_fs),
    .csr_wr_xs     (csr_wr_xs),
    .illegal_req   (illegal_req),
    .fs_state      (fs_state),
    .xs_state      (xs_state)
);

// File: tb/ext_ctx_status_bench.sv
`timescale 1ns/1ps
module ext_ctx_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0, ins_fp_access = 1'b0, ins_fp_write = 1'b0;
    logic       ins_cx_op = 1'b0, retire = 1'b0, csr_wr_en = 1'b0;
    logic [1:0] csr_wr_fs = 2'd0, csr_wr_xs = 2'd0;
    logic       illegal_req, illegal_a;
    logic [1:0] fs_state, xs_state, fs_a, xs_a;

    always #2 clk = ~clk;

    ext_ctx_status u_ext_ctx_status (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_fp_access(ins_fp_access),
        .ins_fp_write(ins_fp_write), .ins_cx_op(ins_cx_op), .retire(retire),
        .csr_wr_en(csr_wr_en), .csr_wr_fs(csr_wr_fs), .csr_wr_xs(csr_wr_xs),
        .illegal_req(illegal_req), .fs_state(fs_state), .xs_state(xs_state));

    ext_ctx_status #(.HAS_FP(1'b0), .HAS_CX(1'b0)) u_ext_ctx_status_absent (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_fp_access(ins_fp_access),
        .ins_fp_write(ins_fp_write), .ins_cx_op(ins_cx_op), .retire(retire),
        .csr_wr_en(csr_wr_en), .csr_wr_fs(csr_wr_fs), .csr_wr_xs(csr_wr_xs),
        .illegal_req(illegal_a), .fs_state(fs_a), .xs_state(xs_a));

    typedef struct {
        string      req;
        logic       ill;
        logic       ill_a;
        logic [1:0] fs;
        logic [1:0] xs;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [1:0] fs_m = 2'd0, xs_m = 2'd0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input string req, input bit v, input bit fpa, input bit fpw,
                         input bit cx, input bit ret, input bit wr,
                         input logic [1:0] wfs, input logic [1:0] wxs);
        exp_t e;
        logic [1:0] bfs, bxs;
        bit ill, commit;
        @(negedge clk);
        ins_valid = v; ins_fp_access = fpa; ins_fp_write = fpw; ins_cx_op = cx;
        retire = ret; csr_wr_en = wr; csr_wr_fs = wfs; csr_wr_xs = wxs;
        ill = v && (((fpa || fpw) && fs_m == 2'd0) || (cx && xs_m == 2'd0));
        commit = v && ret && !ill;
        bfs = wr ? wfs : fs_m;
        bxs = wr ? wxs : xs_m;
        fs_m = (commit && fpw && bfs != 2'd0) ? 2'd3 : bfs;
        xs_m = (commit && cx && bxs != 2'd0) ? 2'd3 : bxs;
        e.req = req; e.ill = ill; e.ill_a = v && (fpa || fpw || cx);
        e.fs = fs_m; e.xs = xs_m;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q[0];
                chk(e.req, "illegal_req", illegal_req, e.ill);
                chk("R9", "absent illegal_req", illegal_a, e.ill_a);
                @(posedge clk);
                #1;
                chk(e.req, "fs_state", fs_state, e.fs);
                chk(e.req, "xs_state", xs_state, e.xs);
                chk("R9", "absent fs_state", fs_a, 0);
                chk("R9", "absent xs_state", xs_a, 0);
                void'(q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1", "fs_state", fs_state, 0);
        chk("R1", "xs_state", xs_state, 0);
        chk("R1", "illegal_req", illegal_req, 0);
        //      req   v  fpa fpw cx ret wr wfs   wxs
        drive("R10", 0, 1, 1, 1, 1, 0, 2'd0, 2'd0);   // flags without valid: no trap
        drive("R2",  1, 1, 0, 0, 1, 0, 2'd0, 2'd0);   // fp read while Off
        drive("R6",  1, 1, 1, 0, 1, 0, 2'd0, 2'd0);   // fp write while Off: no mark
        drive("R3",  1, 0, 0, 1, 1, 0, 2'd0, 2'd0);   // custom op while Off
        for (int k = 0; k < 4; k++)                    // R7 all codes
            drive("R7", 0, 0, 0, 0, 0, 1, 2'(k), 2'(3 - k));
        drive("R7",  0, 0, 0, 0, 0, 1, 2'd1, 2'd1);   // both Initial
        drive("R10", 1, 1, 1, 1, 0, 0, 2'd0, 2'd0);   // no retire: hold
        drive("R4",  1, 1, 0, 0, 1, 0, 2'd0, 2'd0);   // read only: stays Initial
        drive("R4",  1, 1, 1, 0, 1, 0, 2'd0, 2'd0);   // Initial -> Dirty
        drive("R5",  1, 0, 0, 1, 1, 0, 2'd0, 2'd0);   // Initial -> Dirty
        drive("R7",  0, 0, 0, 0, 0, 1, 2'd2, 2'd2);   // both Clean
        drive("R4",  1, 1, 1, 0, 1, 0, 2'd0, 2'd0);   // Clean -> Dirty
        drive("R5",  1, 0, 0, 1, 1, 0, 2'd0, 2'd0);   // Clean -> Dirty
        drive("R7",  0, 0, 0, 0, 0, 1, 2'd2, 2'd0);   // fs Clean, xs Off
        drive("R6",  1, 1, 1, 1, 1, 0, 2'd0, 2'd0);   // custom trap blocks fp mark
        drive("R8",  1, 1, 1, 0, 1, 1, 2'd1, 2'd0);   // write Initial + fp write -> Dirty
        drive("R8",  1, 1, 1, 0, 1, 1, 2'd0, 2'd2);   // write Off + fp write -> Off
        drive("R8",  1, 0, 0, 1, 1, 1, 2'd2, 2'd1);   // write xs Initial + custom -> Dirty
        drive("R8",  1, 0, 0, 1, 1, 1, 2'd2, 2'd0);   // write xs Off + custom -> Off
        drive("R3",  1, 0, 0, 1, 1, 0, 2'd0, 2'd0);   // custom op after Off write
        drive("R10", 0, 0, 0, 0, 0, 0, 2'd0, 2'd0);
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule